// File: doc/BRIEF.md
# Stopwatch Counter with Rotating Tenths Bar and Segment Digits

This block is a synchronous elapsed-time counter. It has three display outputs. The tenths position drives a bar of ten active-low lines, and exactly one line is pulled low at any time. On every step the low line moves one place toward the top of the bar. When the bar wraps, the bottom line stays low for one extra step, so a full turn of the bar takes eleven steps. Each wrap of the bar advances a units digit from 0 to 9. Each wrap of the units digit advances a tens digit from 0 to 5. Both digits leave the block already encoded for active-low seven-segment displays.

A prescaler turns a programmable number of enabled clocks into one tenths step. A divide-by-one setting makes the bar move on every enabled clock, which keeps simulation short. A single `hold` level freezes the whole count, including the prescaler, while it is high. A synchronous reset returns every position to its starting value. The reset may be applied at any point in the count.

Top module: `stopwatch_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next state shows `tenths_n` = 10'b1111111110 (bit 0 low), and both segment outputs show the glyph for 0, which is 7'b1000000.
- R2: `tenths_n` always has exactly one bit at 0 and all other bits at 1.
- R3: On a tenths step, the low bit of `tenths_n` moves from bit k to bit k+1 for k from 1 to 8. From bit 9 it returns to bit 0.
- R4: The bit-0-low pattern lasts for two consecutive steps: the step that wraps from bit 9 and the step after it. One full turn of the bar is therefore eleven steps. The first step after reset also leaves the pattern at 10'b1111111110.
- R5: The step that moves the low bit from bit 9 to bit 0 increments the units digit. When the units digit wraps from 9 to 0, the tens digit increments.
- R6: The tens digit counts 0 to 5 and wraps to 0 on the carry after 5. After 660 steps from reset, all outputs are back at their reset values.
- R7: While `hold` is high, all three outputs and the prescale progress stay unchanged.
- R8: Raising `rst` in the middle of a count clears the tenths phase, both digits and the prescale count at the next edge.
- R9: With `hold` low, a tenths step happens once every TICK_DIV rising edges. Prescale progress made before a hold carries on after the hold ends.
- R10: Segment outputs are active low with bit order {g,f,e,d,c,b,a}. The glyphs are: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | High freezes the count; low lets it run |
| tenths_n | output | 10 | Tenths bar, one line low |
| ones_seg_n | output | 7 | Units digit, active-low segments {g,f,e,d,c,b,a} |
| tens_seg_n | output | 7 | Tens digit, active-low segments {g,f,e,d,c,b,a} |

## Verification
The bench builds the block with TICK_DIV set to 3. At that setting the prescaler's counting variant is in use, so the bench can pause the count partway through a prescale interval and check that the progress made before the pause is kept. It can also check that the first step lands exactly on the third edge. The full 660-step cycle, including the tens wrap after 5, takes about two thousand clocks at this setting, so the bench runs the complete rollover while comparing every output on every clock.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;

    localparam int SEG_W = 7;
    localparam int BCD_W = 4;

    // Active-low glyph, bit order {g,f,e,d,c,b,a}; blank for non-decimal codes.
    function automatic logic [SEG_W-1:0] bcd_to_seg_n(input logic [BCD_W-1:0] v);
        logic [SEG_W-1:0] s;
        case (v)
            4'd0:    s = 7'b1000000;
            4'd1:    s = 7'b1111001;
            4'd2:    s = 7'b0100100;
            4'd3:    s = 7'b0110000;
            4'd4:    s = 7'b0011001;
            4'd5:    s = 7'b0010010;
            4'd6:    s = 7'b0000010;
            4'd7:    s = 7'b1111000;
            4'd8:    s = 7'b0000000;
            4'd9:    s = 7'b0010000;
            default: s = 7'b1111111;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sw_prescale.sv
module sw_prescale #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
            } pre_state_t;

            pre_state_t st_d, st_q;
            logic       tick_d;

            always_comb begin
                st_d   = st_q;
                tick_d = 1'b0;
                if (run) begin
                    if (st_q.cnt == LAST) begin
                        st_d.cnt = '0;
                        tick_d   = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= '0;
                else     st_q <= st_d;
            end

            assign tick = tick_d;

            // R7: no prescale progress while stopped
            p_hold_r7: assert property (@(posedge clk) disable iff (rst)
                !run |=> $stable(st_q.cnt));
            // R9: prescale count stays inside its interval
            p_bound_r9: assert property (@(posedge clk) disable iff (rst)
                st_q.cnt <= LAST);
            // R9: a step restarts the interval
            p_restart_r9: assert property (@(posedge clk) disable iff (rst)
                tick |=> st_q.cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/sw_tenths_ring.sv
module sw_tenths_ring #(
    parameter int LINES = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [LINES-1:0] lines_n,
    output logic             carry
);

    localparam int PHASES = LINES + 1;
    localparam int PW     = $clog2(PHASES);
    localparam logic [PW-1:0] TOP = PW'(LINES);

    typedef struct packed {
        logic [PW-1:0] phase;
    } ring_state_t;

    ring_state_t   st_d, st_q;
    logic          carry_d;
    logic [PW-1:0] lit;

    always_comb begin
        st_d    = st_q;
        carry_d = tick && (st_q.phase == TOP);
        if (tick) begin
            if (carry_d) st_d.phase = '0;
            else         st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Phases 0 and 1 both light line 0 (the dwell); phase k lights line k-1.
    assign lit   = (st_q.phase == '0) ? '0 : st_q.phase - 1'b1;
    assign carry = carry_d;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            assign lines_n[i] = (lit != PW'(i));
        end
    endgenerate

    p_range_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.phase <= TOP);
    p_onecold_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(~lines_n) == 1);
    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && st_q.phase != '0 && st_q.phase != TOP)
        |=> lines_n == {$past(lines_n[LINES-2:0]), 1'b1});
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && st_q.phase == TOP) |=> !lines_n[0]);
    p_dwell_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && st_q.phase == '0) |=> !lines_n[0]);

endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit
    import stopwatch_pkg::*;
#(
    parameter int MAX = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [BCD_W-1:0] value,
    output logic             carry
);

    localparam logic [BCD_W-1:0] LIM = BCD_W'(MAX);

    typedef struct packed {
        logic [BCD_W-1:0] v;
    } digit_state_t;

    digit_state_t st_d, st_q;
    logic         carry_d;

    always_comb begin
        st_d    = st_q;
        carry_d = inc && (st_q.v == LIM);
        if (inc) begin
            if (carry_d) st_d.v = '0;
            else         st_d.v = st_q.v + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign value = st_q.v;
    assign carry = carry_d;

    p_range_r6: assert property (@(posedge clk) disable iff (rst)
        st_q.v <= LIM);
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (inc && st_q.v == LIM) |=> value == '0);
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(value));

endmodule

// File: rtl/sw_seg_enc.sv
module sw_seg_enc
    import stopwatch_pkg::*;
(
    input  logic [BCD_W-1:0] digit,
    output logic [SEG_W-1:0] seg_n
);

    assign seg_n = bcd_to_seg_n(digit);

    // R10: a decimal code never leaves the display blank
    always_comb begin
        if (digit <= 4'd9) begin
            p_lit_r10: assert (seg_n != 7'b1111111);
        end
    end

endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
    import stopwatch_pkg::*;
#(
    parameter int TICK_DIV = 1,
    parameter int ONES_MAX = 9,
    parameter int TENS_MAX = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    output logic [9:0]       tenths_n,
    output logic [SEG_W-1:0] ones_seg_n,
    output logic [SEG_W-1:0] tens_seg_n
);

    localparam int DIGITS = 2;
    localparam int LINES  = 10;
    localparam logic [SEG_W-1:0] ZERO_GLYPH = 7'b1000000;
    localparam logic [LINES-1:0] HOME       = ~(LINES'(1));

    logic                        tick;
    logic                        ring_carry;
    logic [DIGITS-1:0]           inc;
    logic [DIGITS-1:0]           dcarry;
    logic [DIGITS-1:0][BCD_W-1:0] dval;
    logic [DIGITS-1:0][SEG_W-1:0] dseg;

    sw_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (!hold),
        .tick (tick)
    );

    sw_tenths_ring #(.LINES(LINES)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .lines_n (tenths_n),
        .carry   (ring_carry)
    );

    generate
        for (genvar i = 0; i < DIGITS; i++) begin : g_digit
            localparam int DMAX = (i == 0) ? ONES_MAX : TENS_MAX;
            if (i == 0) begin : g_first
                assign inc[i] = ring_carry;
            end else begin : g_next
                assign inc[i] = dcarry[i-1];
            end
            sw_bcd_digit #(.MAX(DMAX)) u_dig (
                .clk   (clk),
                .rst   (rst),
                .inc   (inc[i]),
                .value (dval[i]),
                .carry (dcarry[i])
            );
            sw_seg_enc u_seg (
                .digit (dval[i]),
                .seg_n (dseg[i])
            );
        end
    endgenerate

    assign ones_seg_n = dseg[0];
    assign tens_seg_n = dseg[1];

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (tenths_n == HOME && ones_seg_n == ZERO_GLYPH && tens_seg_n == ZERO_GLYPH));
    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(tenths_n) && $stable(ones_seg_n) && $stable(tens_seg_n)));
    p_rollover_r6: assert property (@(posedge clk) disable iff (rst)
        dcarry[DIGITS-1] |=> (ones_seg_n == ZERO_GLYPH && tens_seg_n == ZERO_GLYPH
                              && tenths_n == HOME));

endmodule

// File: tb/stopwatch_core_test.sv
module stopwatch_core_test;

    localparam int DIV  = 3;
    localparam int TURN = 11 * DIV;

    logic       clk  = 1'b0;
    logic       rst  = 1'b1;
    logic       hold = 1'b1;
    logic [9:0] tenths_n;
    logic [6:0] ones_seg_n;
    logic [6:0] tens_seg_n;

    int  errs   = 0;
    int  checks = 0;
    bit  done   = 1'b0;
    bit  saw5   = 1'b0;
    int  m_pre  = 0;
    int  m_ph   = 0;
    int  m_ones = 0;
    int  m_tens = 0;

    always #4 clk = ~clk;

    stopwatch_core #(.TICK_DIV(DIV)) uut (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .tenths_n   (tenths_n),
        .ones_seg_n (ones_seg_n),
        .tens_seg_n (tens_seg_n)
    );

    function automatic logic [6:0] glyph(input int v);
        case (v)
            0: return 7'b1000000;
            1: return 7'b1111001;
            2: return 7'b0100100;
            3: return 7'b0110000;
            4: return 7'b0011001;
            5: return 7'b0010010;
            6: return 7'b0000010;
            7: return 7'b1111000;
            8: return 7'b0000000;
            9: return 7'b0010000;
            default: return 7'b1111111;
        endcase
    endfunction

    function automatic logic [9:0] bar(input int ph);
        int b;
        b = (ph == 0) ? 0 : ph - 1;
        return ~(10'd1 << b);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_pre = 0; m_ph = 0; m_ones = 0; m_tens = 0;
        end else if (!hold) begin
            m_pre++;
            if (m_pre == DIV) begin
                m_pre = 0;
                m_ph++;
                if (m_ph == 11) begin
                    m_ph = 0;
                    m_ones++;
                    if (m_ones == 10) begin
                        m_ones = 0;
                        m_tens++;
                        if (m_tens == 6) m_tens = 0;
                    end
                end
            end
        end
    endtask

    task automatic compare_all();
        chk(tenths_n == bar(m_ph), "R3", "tenths", 32'(tenths_n), 32'(bar(m_ph)));
        chk($countones(~tenths_n) == 1, "R2", "one-cold", 32'(tenths_n), 32'(bar(m_ph)));
        chk(ones_seg_n == glyph(m_ones), "R5", "ones", 32'(ones_seg_n), 32'(glyph(m_ones)));
        chk(tens_seg_n == glyph(m_tens), "R6", "tens", 32'(tens_seg_n), 32'(glyph(m_tens)));
        if (m_tens == 5 && tens_seg_n == 7'b0010010) saw5 = 1'b1;
    endtask

    task automatic cycles(input int n);
        repeat (n) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        logic [9:0] snap_t;
        logic [6:0] snap_o;
        rst = 1'b1; hold = 1'b1;
        cycles(3);
        // R1 reset state
        chk(tenths_n == 10'b1111111110, "R1", "reset tenths", 32'(tenths_n), 32'h3FE);
        chk(ones_seg_n == 7'b1000000 && tens_seg_n == 7'b1000000, "R1", "reset segs",
            32'({ones_seg_n, tens_seg_n}), 32'({7'b1000000, 7'b1000000}));

        rst = 1'b0; hold = 1'b0;
        cycles(DIV - 1);
        chk(tenths_n == 10'b1111111110, "R9", "before first step", 32'(tenths_n), 32'h3FE);
        cycles(1);
        chk(tenths_n == 10'b1111111110, "R4", "first step dwells", 32'(tenths_n), 32'h3FE);
        cycles(DIV);
        chk(tenths_n == 10'b1111111101, "R3", "second step", 32'(tenths_n), 32'h3FD);

        // R7 / R9: pause partway through a prescale interval
        cycles(1);
        hold = 1'b1;
        snap_t = tenths_n; snap_o = ones_seg_n;
        cycles(10);
        chk(tenths_n == snap_t && ones_seg_n == snap_o, "R7", "held outputs",
            32'(tenths_n), 32'(snap_t));
        hold = 1'b0;
        cycles(DIV - 2);
        chk(tenths_n == 10'b1111111101, "R9", "progress kept, no step yet", 32'(tenths_n), 32'h3FD);
        cycles(1);
        chk(tenths_n == 10'b1111111011, "R9", "step after resume", 32'(tenths_n), 32'h3FB);

        // R8 mid-count reset
        cycles(5 * DIV + 1);
        rst = 1'b1;
        cycles(1);
        chk(tenths_n == 10'b1111111110 && ones_seg_n == 7'b1000000, "R8", "mid-count reset",
            32'(tenths_n), 32'h3FE);
        rst = 1'b0;
        cycles(DIV);
        chk(tenths_n == 10'b1111111110, "R8", "prescaler cleared", 32'(tenths_n), 32'h3FE);
        cycles(TURN - DIV - 1);
        chk(tenths_n == 10'b0111111111, "R3", "bit 9 low", 32'(tenths_n), 32'h1FF);
        cycles(1);
        chk(tenths_n == 10'b1111111110, "R4", "wrap to bit 0", 32'(tenths_n), 32'h3FE);
        chk(ones_seg_n == 7'b1111001, "R5", "ones after one turn", 32'(ones_seg_n), 32'b1111001);
        cycles(DIV);
        chk(tenths_n == 10'b1111111110, "R4", "dwell after wrap", 32'(tenths_n), 32'h3FE);
        cycles(TURN * 8 - DIV);
        chk(ones_seg_n == 7'b0010000, "R10", "glyph 9", 32'(ones_seg_n), 32'b0010000);
        cycles(TURN);
        chk(ones_seg_n == 7'b1000000 && tens_seg_n == 7'b1111001, "R5", "units carry to tens",
            32'({ones_seg_n, tens_seg_n}), 32'({7'b1000000, 7'b1111001}));
        cycles(TURN * 7);
        chk(ones_seg_n == 7'b1111000, "R10", "glyph 7", 32'(ones_seg_n), 32'b1111000);
        cycles(TURN);
        chk(ones_seg_n == 7'b0000000, "R10", "glyph 8", 32'(ones_seg_n), 32'b0000000);
        cycles(TURN * 42);
        chk(saw5 && tens_seg_n == 7'b1000000 && ones_seg_n == 7'b1000000
            && tenths_n == 10'b1111111110, "R6", "full rollover",
            32'({tens_seg_n, ones_seg_n}), 32'({7'b1000000, 7'b1000000}));

        hold = 1'b1;
        cycles(DIV * 4);
        chk(tenths_n == 10'b1111111110 && tens_seg_n == 7'b1000000, "R7", "hold after rollover",
            32'(tenths_n), 32'h3FE);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule